// File: doc/BRIEF.md
# Segment Carryover Pointer Update Unit

This unit computes the next value of an 8-bit pointer register and of the 8-bit segment register paired with it. Each cycle it can take one request: an increment of the selected pointer, or a relative move that adds a signed 8-bit offset to it. The new pointer, the new segment, a segment write strobe and the combined 16-bit address appear on registered outputs one clock after the request. The register file that stores the values, and the instruction decoder that issues requests, are outside the block.

Two pairs can act as one 16-bit address: the instruction pointer with the code segment, and the stack pointer with the stack segment. Each pair has its own carryover flag, set and cleared by command inputs. While a pair's flag is set, a pointer result that passes above 255 increments the segment and one that falls below 0 decrements it. The linear address is the segment in the high byte and the pointer in the low byte, so a walk that starts at 0:0 steps through memory in order. Every other target register gets plain 8-bit wraparound, and the segment is left alone.

Top module: `scu_ptr_update`

## Requirements
- R1: While reset is asserted and after it is released, `ptr_out`, `seg_out`, `addr_out`, `seg_wr_en` and `upd_valid` are zero and both carryover flags are cleared, so an instruction-pointer increment from 255 right after reset leaves the segment unwritten.
- R2: With `incr_req`=1 and `rel_req`=0, the next cycle shows `upd_valid`=1 and `ptr_out` = (`ptr_in` + 1) mod 256.
- R3: With `rel_req`=1, the next cycle shows `upd_valid`=1 and `ptr_out` = (`ptr_in` + signed `rel_off`) mod 256, with `rel_off` in two's complement (50 plus 0xF6 gives 40).
- R4: For `tgt_sel`=7 (instruction pointer, paired with the code segment) and the code carryover flag set, a result above 255 gives `seg_out` = (`seg_in` + 1) mod 256 and `seg_wr_en`=1 in the next cycle.
- R5: For `tgt_sel`=6 (stack pointer, paired with the stack segment), the same carry and borrow rules apply under the stack carryover flag.
- R6: For a paired target with its flag set, a result below 0 gives `seg_out` = (`seg_in` - 1) mod 256 and `seg_wr_en`=1 in the next cycle.
- R7: For `tgt_sel` 0 to 5 (general registers), `seg_wr_en` stays 0 and `seg_out` equals the `seg_in` given with the request, whatever the flags.
- R8: For a paired target whose flag is clear, the pointer wraps within 8 bits, `seg_wr_en` stays 0 and `seg_out` equals `seg_in`.
- R9: `code_carry_on`/`code_carry_off` set/clear the code flag and `stack_carry_on`/`stack_carry_off` the stack flag, independently. A command acts from the next cycle: a request in the same cycle uses the old flag value. When set and clear are given together, clear wins.
- R10: `addr_out` always equals {`seg_out`, `ptr_out`}. Repeated code-pair increments that start at 0:0 with the code flag set step the address by one each time, across segment boundaries.
- R11: When both requests are given, the relative move is taken. With no request, the next cycle shows `upd_valid`=0 and `seg_wr_en`=0, and `ptr_out`, `seg_out` and `addr_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tgt_sel | input | 3 | Target register: 0-5 general, 6 stack pointer, 7 instruction pointer |
| ptr_in | input | 8 | Current value of the target register |
| seg_in | input | 8 | Current value of the segment paired with the target |
| rel_off | input | 8 | Signed offset for a relative move |
| incr_req | input | 1 | Increment the target by one |
| rel_req | input | 1 | Add `rel_off` to the target |
| code_carry_on | input | 1 | Set the code-pair carryover flag |
| code_carry_off | input | 1 | Clear the code-pair carryover flag |
| stack_carry_on | input | 1 | Set the stack-pair carryover flag |
| stack_carry_off | input | 1 | Clear the stack-pair carryover flag |
| ptr_out | output | 8 | New pointer value |
| seg_out | output | 8 | New segment value |
| seg_wr_en | output | 1 | Segment register must be written with `seg_out` |
| addr_out | output | 16 | Linear address, segment high byte and pointer low byte |
| upd_valid | output | 1 | An update was computed in the previous cycle |

## Verification
A carryover flag stuck in the wrong state shows up on the first request that crosses a byte boundary on that pair: `seg_wr_en` and `seg_out` differ from the expected values one cycle after that request. Sign or borrow errors in the adder show as a wrong `ptr_out` on the next cycle for any negative offset. Because the pointer result and the segment decision are both registered in the same cycle, every fault becomes visible exactly one clock after the request that exposes it. The sweeps therefore cover every pointer value against offsets at the edges of the signed range, on general and on paired targets, with each flag set and cleared.

// File: rtl/scu_pkg.sv
package scu_pkg;

    // Result of adding a signed step to an unsigned pointer
    typedef enum logic [1:0] {
        WRAP_NONE  = 2'd0,
        WRAP_OVER  = 2'd1,
        WRAP_UNDER = 2'd2
    } wrap_e;

    // Index of each carryover pair in the flag vector
    localparam int unsigned PAIR_CODE  = 0;
    localparam int unsigned PAIR_STACK = 1;
    localparam int unsigned NUM_PAIRS  = 2;

endpackage

// File: rtl/scu_delta.sv
module scu_delta #(
    parameter int unsigned W = 8
) (
    input  logic         incr_req,
    input  logic         rel_req,
    input  logic [W-1:0] rel_off,
    output logic [W:0]   delta,
    output logic         active
);

    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    always_comb begin
        active = incr_req | rel_req;
        if (rel_req) begin
            delta = {rel_off[W-1], rel_off};
        end else if (incr_req) begin
            delta = ONE;
        end else begin
            delta = '0;
        end
    end

endmodule

// File: rtl/scu_wrap_detect.sv
module scu_wrap_detect
    import scu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] ptr,
    input  logic [W:0]   delta,
    output logic [W-1:0] result,
    output wrap_e        wrap
);

    localparam int unsigned SUM_W = W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum    = {2'b00, ptr} + {delta[W], delta};
        result = sum[W-1:0];
        if (sum[SUM_W-1]) begin
            wrap = WRAP_UNDER;
        end else if (sum[W]) begin
            wrap = WRAP_OVER;
        end else begin
            wrap = WRAP_NONE;
        end
    end

    // R3: a positive step never borrows and a negative one never carries
    always_comb begin
        a_r3_wrap_direction: assert (!(delta[W] && wrap == WRAP_OVER) &&
                                     !(!delta[W] && wrap == WRAP_UNDER))
            else $error("wrap direction disagrees with step sign");
    end

endmodule

// File: rtl/scu_carry_flags.sv
module scu_carry_flags #(
    parameter int unsigned NPAIR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] set_req,
    input  logic [NPAIR-1:0] clr_req,
    output logic [NPAIR-1:0] en_q
);

    logic [NPAIR-1:0] en_d;

    for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
        always_comb begin
            en_d[gi] = en_q[gi];
            if (clr_req[gi]) begin
                en_d[gi] = 1'b0;
            end else if (set_req[gi]) begin
                en_d[gi] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[gi] <= 1'b0;
            end else begin
                en_q[gi] <= en_d[gi];
            end
        end

        // R9: clear dominates a simultaneous set
        a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[gi] |=> !en_q[gi]);

        // R9: a lone set takes hold on the next cycle
        a_r9_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[gi] && !clr_req[gi]) |=> en_q[gi]);

        // R9: with no command the flag keeps its value
        a_r9_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_req[gi] && !clr_req[gi]) |=> $stable(en_q[gi]));
    end

endmodule

// File: rtl/scu_ptr_update.sv
module scu_ptr_update
    import scu_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned SP_SEL = 6,
    parameter int unsigned IP_SEL = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic [W-1:0]     ptr_in,
    input  logic [W-1:0]     seg_in,
    input  logic [W-1:0]     rel_off,
    input  logic             incr_req,
    input  logic             rel_req,
    input  logic             code_carry_on,
    input  logic             code_carry_off,
    input  logic             stack_carry_on,
    input  logic             stack_carry_off,
    output logic [W-1:0]     ptr_out,
    output logic [W-1:0]     seg_out,
    output logic             seg_wr_en,
    output logic [2*W-1:0]   addr_out,
    output logic             upd_valid
);

    localparam logic [W-1:0]     SEG_ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [SEL_W-1:0] SP_CODE = SEL_W'(SP_SEL);
    localparam logic [SEL_W-1:0] IP_CODE = SEL_W'(IP_SEL);

    typedef struct packed {
        logic [W-1:0] ptr;
        logic [W-1:0] seg;
        logic         seg_we;
        logic         valid;
    } upd_t;

    upd_t             st_d;
    upd_t             st_q;
    logic [W:0]       delta;
    logic             active;
    logic [W-1:0]     sum_ptr;
    wrap_e            wrap;
    logic [NUM_PAIRS-1:0] flag_set;
    logic [NUM_PAIRS-1:0] flag_clr;
    logic [NUM_PAIRS-1:0] flag_en;
    logic             pair_en;

    always_comb begin
        flag_set             = '0;
        flag_clr             = '0;
        flag_set[PAIR_CODE]  = code_carry_on;
        flag_clr[PAIR_CODE]  = code_carry_off;
        flag_set[PAIR_STACK] = stack_carry_on;
        flag_clr[PAIR_STACK] = stack_carry_off;
    end

    scu_delta #(.W(W)) i_delta (
        .incr_req (incr_req),
        .rel_req  (rel_req),
        .rel_off  (rel_off),
        .delta    (delta),
        .active   (active)
    );

    scu_wrap_detect #(.W(W)) i_wrap (
        .ptr    (ptr_in),
        .delta  (delta),
        .result (sum_ptr),
        .wrap   (wrap)
    );

    scu_carry_flags #(.NPAIR(NUM_PAIRS)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (flag_set),
        .clr_req (flag_clr),
        .en_q    (flag_en)
    );

    always_comb begin
        pair_en = ((tgt_sel == IP_CODE) && flag_en[PAIR_CODE]) ||
                  ((tgt_sel == SP_CODE) && flag_en[PAIR_STACK]);

        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.seg_we = 1'b0;
        if (active) begin
            st_d.valid = 1'b1;
            st_d.ptr   = sum_ptr;
            st_d.seg   = seg_in;
            if (pair_en) begin
                unique case (wrap)
                    WRAP_OVER: begin
                        st_d.seg    = seg_in + SEG_ONE;
                        st_d.seg_we = 1'b1;
                    end
                    WRAP_UNDER: begin
                        st_d.seg    = seg_in - SEG_ONE;
                        st_d.seg_we = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_out   = st_q.ptr;
    assign seg_out   = st_q.seg;
    assign seg_wr_en = st_q.seg_we;
    assign upd_valid = st_q.valid;
    assign addr_out  = {st_q.seg, st_q.ptr};

    // R4: a segment write only comes with an update
    a_r4_we_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |-> upd_valid);

    // R6: a written segment moved by exactly one step from the given one
    a_r6_seg_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |-> ((seg_out == $past(seg_in) + SEG_ONE) ||
                       (seg_out == $past(seg_in) - SEG_ONE)));

    // R7: general registers never touch the segment
    a_r7_general_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
        ((incr_req || rel_req) && tgt_sel < SP_CODE)
            |=> (!seg_wr_en && seg_out == $past(seg_in)));

    // R2: a lone increment advances the pointer by one
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (incr_req && !rel_req) |=> (ptr_out == $past(ptr_in) + SEG_ONE));

    // R11: no request leaves the outputs idle and held
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!incr_req && !rel_req)
            |=> (!upd_valid && !seg_wr_en && $stable(ptr_out) && $stable(seg_out)));

    // R10: the linear address tracks the two registered bytes
    a_r10_addr_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_out[2*W-1:W] == seg_out) && (addr_out[W-1:0] == ptr_out));

endmodule

// File: tb/test_scu_ptr_update.sv
`timescale 1ns/1ps
module test_scu_ptr_update;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tgt_sel = '0;
    logic [7:0] ptr_in = '0;
    logic [7:0] seg_in = '0;
    logic [7:0] rel_off = '0;
    logic       incr_req = 1'b0;
    logic       rel_req = 1'b0;
    logic       code_carry_on = 1'b0;
    logic       code_carry_off = 1'b0;
    logic       stack_carry_on = 1'b0;
    logic       stack_carry_off = 1'b0;
    logic [7:0] ptr_out;
    logic [7:0] seg_out;
    logic       seg_wr_en;
    logic [15:0] addr_out;
    logic       upd_valid;

    int checks = 0;
    int failures = 0;

    // bench model state
    bit         m_cs_en = 0;
    bit         m_ss_en = 0;
    logic [7:0] m_ptr = '0;
    logic [7:0] m_seg = '0;

    always #5 clk = ~clk;

    scu_ptr_update i_scu_ptr_update (
        .clk             (clk),
        .rst_n           (rst_n),
        .tgt_sel         (tgt_sel),
        .ptr_in          (ptr_in),
        .seg_in          (seg_in),
        .rel_off         (rel_off),
        .incr_req        (incr_req),
        .rel_req         (rel_req),
        .code_carry_on   (code_carry_on),
        .code_carry_off  (code_carry_off),
        .stack_carry_on  (stack_carry_on),
        .stack_carry_off (stack_carry_off),
        .ptr_out         (ptr_out),
        .seg_out         (seg_out),
        .seg_wr_en       (seg_wr_en),
        .addr_out        (addr_out),
        .upd_valid       (upd_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle: drive at a falling edge, check at the next one
    task automatic step(input logic [2:0] s, input logic [7:0] p, input logic [7:0] sg,
                        input logic [7:0] o, input bit inc, input bit rel,
                        input bit con, input bit coff, input bit son, input bit soff,
                        input string tag);
        int   d;
        int   sum;
        bit   pe;
        bit   ev;
        bit   ew;
        tgt_sel = s; ptr_in = p; seg_in = sg; rel_off = o;
        incr_req = inc; rel_req = rel;
        code_carry_on = con; code_carry_off = coff;
        stack_carry_on = son; stack_carry_off = soff;
        d   = rel ? int'($signed(o)) : (inc ? 1 : 0);
        sum = int'(p) + d;
        pe  = (s == 3'd7 && m_cs_en) || (s == 3'd6 && m_ss_en);
        ev  = inc || rel;
        ew  = 0;
        if (ev) begin
            m_ptr = 8'(sum);
            m_seg = sg;
            if (pe && sum > 255) begin m_seg = sg + 8'd1; ew = 1; end
            if (pe && sum < 0)   begin m_seg = sg - 8'd1; ew = 1; end
        end
        if (coff) m_cs_en = 0; else if (con) m_cs_en = 1;
        if (soff) m_ss_en = 0; else if (son) m_ss_en = 1;
        @(negedge clk);
        check(tag, {ptr_out, seg_out, 7'd0, seg_wr_en, 7'd0, upd_valid},
                   {m_ptr, m_seg, 7'd0, ew, 7'd0, ev});
        check("R10", 32'(addr_out), 32'({m_seg, m_ptr}));
    endtask

    task automatic cmd(input bit con, input bit coff, input bit son, input bit soff);
        step(3'd0, 8'd0, 8'd0, 8'd0, 0, 0, con, coff, son, soff, "R9");
    endtask

    initial begin
        logic [7:0] offs [7] = '{8'h80, 8'hF6, 8'hFF, 8'h00, 8'h01, 8'h0A, 8'h7F};
        logic [7:0] segs [3] = '{8'h00, 8'h7F, 8'hFF};
        logic [7:0] wp;
        logic [7:0] ws;
        tgt_sel = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {ptr_out, seg_out}, 16'h0000);
        check("R1", 32'({addr_out, seg_wr_en, upd_valid}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'({addr_out, seg_wr_en, upd_valid}), 32'h0);
        // R1: flags cleared, so a code-pair carry does not write the segment
        step(3'd7, 8'hFF, 8'h12, 8'h00, 1, 0, 0, 0, 0, 0, "R1");
        step(3'd6, 8'h00, 8'h12, 8'hFF, 0, 1, 0, 0, 0, 0, "R1");

        // R3: worked example 50 + (-10)
        step(3'd2, 8'd50, 8'h33, 8'hF6, 0, 1, 0, 0, 0, 0, "R3");
        check("R3", 32'(ptr_out), 32'd40);

        // turn both flags on
        cmd(1, 0, 1, 0);

        // R7: general registers, all pointers, edge offsets, flags on
        for (int s = 0; s < 6; s++)
            for (int p = 0; p < 256; p++)
                for (int k = 0; k < 7; k++)
                    step(3'(s), 8'(p), 8'(p) ^ 8'h5A, offs[k], 0, 1, 0, 0, 0, 0, "R7");

        // R4 / R5 / R6: paired targets with carryover
        for (int s = 6; s < 8; s++)
            for (int g = 0; g < 3; g++)
                for (int p = 0; p < 256; p++)
                    for (int k = 0; k < 7; k++)
                        step(3'(s), 8'(p), segs[g], offs[k], 0, 1, 0, 0, 0, 0,
                             (int'(p) + int'($signed(offs[k])) < 0) ? "R6" :
                             (s == 7 ? "R4" : "R5"));

        // R2: increments on every pointer for both pairs and a general register
        for (int s = 5; s < 8; s++)
            for (int p = 0; p < 256; p++)
                step(3'(s), 8'(p), 8'hFF, 8'h00, 1, 0, 0, 0, 0, 0, "R2");

        // R10: linear walk from 0:0 across two segment boundaries
        wp = 8'h00; ws = 8'h00;
        for (int n = 1; n <= 600; n++) begin
            step(3'd7, wp, ws, 8'h00, 1, 0, 0, 0, 0, 0, "R10");
            check("R10", 32'(addr_out), 32'(n));
            wp = ptr_out; ws = seg_out;
        end

        // R8 / R9: code flag off, stack flag stays on
        cmd(0, 1, 0, 0);
        for (int p = 0; p < 256; p++) begin
            step(3'd7, 8'(p), 8'h40, 8'h80, 0, 1, 0, 0, 0, 0, "R8");
            step(3'd7, 8'(p), 8'h40, 8'h7F, 0, 1, 0, 0, 0, 0, "R8");
            step(3'd6, 8'(p), 8'h40, 8'h7F, 0, 1, 0, 0, 0, 0, "R9");
        end

        // R9: a command in the same cycle as a request acts one cycle later
        step(3'd7, 8'hFF, 8'h01, 8'h00, 1, 0, 1, 0, 0, 0, "R9");
        check("R9", 32'(seg_wr_en), 32'd0);
        step(3'd7, 8'hFF, 8'h01, 8'h00, 1, 0, 0, 0, 0, 0, "R9");
        check("R9", 32'(seg_wr_en), 32'd1);
        // R9: set and clear together -> clear wins, for both pairs
        cmd(1, 1, 1, 1);
        step(3'd7, 8'hFF, 8'h01, 8'h00, 1, 0, 0, 0, 0, 0, "R9");
        step(3'd6, 8'h00, 8'h01, 8'hFF, 0, 1, 0, 0, 0, 0, "R9");
        check("R9", 32'(seg_wr_en), 32'd0);
        // R9: stack flag on alone does not arm the code pair
        cmd(0, 0, 1, 0);
        step(3'd7, 8'hFF, 8'h09, 8'h00, 1, 0, 0, 0, 0, 0, "R9");
        step(3'd6, 8'hFF, 8'h09, 8'h00, 1, 0, 0, 0, 0, 0, "R5");

        // R11: both requests -> relative move taken
        cmd(1, 0, 0, 0);
        step(3'd7, 8'h10, 8'h20, 8'hF0, 1, 1, 0, 0, 0, 0, "R11");
        check("R11", 32'(ptr_out), 32'h00);
        step(3'd3, 8'h10, 8'h20, 8'h05, 1, 1, 0, 0, 0, 0, "R11");
        check("R11", 32'(ptr_out), 32'h15);
        // R11: idle cycles hold outputs while inputs change
        step(3'd7, 8'hFF, 8'hAA, 8'h01, 1, 0, 0, 0, 0, 0, "R4");
        for (int n = 0; n < 4; n++)
            step(3'(n + 4), 8'(n * 37), 8'(n * 11), 8'h80, 0, 0, 0, 0, 0, 0, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule